// File: doc/BRIEF.md
# Supply-Pulse Programming Command Decoder

This block lets a sealed product be configured through its two supply terminals alone. An external level detector turns supply excursions into one-cycle event strobes: start, stop, small modulation pulse, prestore and store. The decoder measures the time between successive modulation pulses in ticks of the 32768 Hz clock. It uses each interval class to step an instruction counter or to shift a bit into an 8-bit shift register.

The instruction counter selects one of six states:
- oscillator measurement
- inhibition measurement
- three writable configuration words
- a read-only type word

A prestore followed by a store copies the shift register into the selected word. The words model one-time-programmable cells, so a write can only set bits. For read-back, a single 1 is walked through the shift register, and a load output shows whether the addressed bit of the selected word is set. An instruction state ends on a stop pulse or a store pulse. It also ends by itself when no modulation pulse arrives for a programmable number of ticks.

Top module: `supply_cmd_decoder`

## Requirements
- R1: A start strobe, from any state, sets `instr_state` to 1 (oscillator measurement), clears `shreg` and restarts the interval count. States: 0 idle, 1 oscillator measurement, 2 inhibition measurement, 3 to 5 configuration words 0 to 2, 6 type word.
- R2: Modulation pulses that arrive before WAIT_TICKS ticks have elapsed since the start strobe have no effect.
- R3: The first modulation pulse accepted after the wait only sets the timing reference; state and register are unchanged.
- R4: The interval between two pulses is the number of tick strobes in the cycles strictly between them. An interval in INC_LO..INC_HI (default 20..26) increments `instr_state`, which stops at 6.
- R5: An interval in ZERO_LO..ZERO_HI (default 53..58) shifts a 0, and one in ONE_LO..ONE_HI (default 86..91) shifts a 1. The new bit enters at bit 7 and the old contents move one place toward bit 0, so the first of eight bits ends in bit 0.
- R6: An interval outside all three windows changes nothing, but that pulse becomes the new timing reference.
- R7: Configuration word bits never go from 1 to 0. A write ORs `shreg` into the word.
- R8: A store strobe preceded by a prestore strobe, in states 3, 4 or 5, raises `prog_wr` for one cycle and writes word 0, 1 or 2. A store without a prior prestore, or in states 1, 2 or 6, writes nothing.
- R9: A stop strobe or a store strobe returns the decoder to idle (state 0). In idle, modulation, prestore and store strobes are ignored.
- R10: After TIMEOUT_TICKS ticks without an accepted modulation pulse since the last pulse or start, the decoder returns to idle.
- R11: `rd_load` is 1 exactly when the state is 3 to 6 and `shreg` ANDed with the selected word is non-zero. Word 6 is the TYPE_ID parameter.
- R12: After reset the state is idle, `shreg` and all words are 0, and `prog_wr` and `rd_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe at 32768 Hz |
| ev_start | input | 1 | Start excursion detected |
| ev_stop | input | 1 | Stop excursion detected |
| ev_mod | input | 1 | Small modulation pulse detected |
| ev_prestore | input | 1 | Prestore excursion detected |
| ev_store | input | 1 | Store excursion detected |
| instr_state | output | 3 | Instruction counter (0 idle, 1..6) |
| shreg | output | 8 | Data / pointer shift register |
| prog_wr | output | 1 | One-cycle write strobe to the cell array |
| rd_load | output | 1 | Read-back load enable |
| word0 | output | 8 | Configuration word 0 |
| word1 | output | 8 | Configuration word 1 |
| word2 | output | 8 | Configuration word 2 |

## Verification
The assertions assume that each event strobe lasts one cycle and that at most one event strobe is high in any cycle. They rely on the decoder's own priority order only for start over all other strobes. The stimulus follows these assumptions: every event comes from a task that raises one strobe for a single cycle between falling edges, and the tick strobe is held high so that tick counts equal cycle counts. Random intervals are drawn inside the accepted windows or in the gap between the increment and shift-0 windows, and the exact window edges are exercised by directed cases.

// File: rtl/supply_cmd_pkg.sv
package supply_cmd_pkg;
    typedef enum logic [1:0] {
        IV_NONE = 2'd0,
        IV_INC  = 2'd1,
        IV_ZERO = 2'd2,
        IV_ONE  = 2'd3
    } ivl_e;

    localparam logic [2:0] ST_IDLE  = 3'd0;
    localparam logic [2:0] ST_OSC   = 3'd1;
    localparam logic [2:0] ST_WORD0 = 3'd3;
    localparam logic [2:0] ST_WORD2 = 3'd5;
    localparam logic [2:0] ST_TYPE  = 3'd6;
endpackage

// File: rtl/interval_classifier.sv
module interval_classifier
    import supply_cmd_pkg::*;
#(
    parameter int unsigned CW      = 11,
    parameter int unsigned INC_LO  = 20,
    parameter int unsigned INC_HI  = 26,
    parameter int unsigned ZERO_LO = 53,
    parameter int unsigned ZERO_HI = 58,
    parameter int unsigned ONE_LO  = 86,
    parameter int unsigned ONE_HI  = 91
) (
    input  logic [CW-1:0] ticks,
    output ivl_e          cls
);
    localparam int unsigned IW = CW + 1;
    logic [IW-1:0] t_ext;

    always_comb begin
        t_ext = {1'b0, ticks};
        cls   = IV_NONE;
        if (t_ext >= IW'(INC_LO) && t_ext <= IW'(INC_HI)) begin
            cls = IV_INC;
        end else if (t_ext >= IW'(ZERO_LO) && t_ext <= IW'(ZERO_HI)) begin
            cls = IV_ZERO;
        end else if (t_ext >= IW'(ONE_LO) && t_ext <= IW'(ONE_HI)) begin
            cls = IV_ONE;
        end
    end
endmodule

// File: rtl/otp_bank.sv
module otp_bank
    import supply_cmd_pkg::*;
#(
    parameter int unsigned DW      = 8,
    parameter int unsigned NWORDS  = 3,
    parameter logic [7:0]  TYPE_ID = 8'h03
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [1:0]             wsel,
    input  logic [DW-1:0]          wdata,
    input  logic [2:0]             st,
    input  logic [DW-1:0]          ptr,
    output logic [NWORDS*DW-1:0]   words,
    output logic                   rd_load
);
    logic [DW-1:0] cell_d [NWORDS];
    logic [DW-1:0] cell_q [NWORDS];
    logic [DW-1:0] rd_word;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_comb begin
            cell_d[g] = cell_q[g];
            if (wr && wsel == 2'(g)) begin
                cell_d[g] = cell_q[g] | wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q[g] <= '0;
            else        cell_q[g] <= cell_d[g];
        end

        assign words[g*DW +: DW] = cell_q[g];

        assert_otp_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (($past(cell_q[g]) & ~cell_q[g]) == '0));

        assert_otp_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && wsel == 2'(g)) |=> ((cell_q[g] & $past(wdata)) == $past(wdata)));
    end

    always_comb begin
        rd_word = '0;
        if (st >= ST_WORD0 && st <= ST_WORD2) begin
            rd_word = cell_q[st - ST_WORD0];
        end else if (st == ST_TYPE) begin
            rd_word = DW'(TYPE_ID);
        end
        rd_load = |(rd_word & ptr);
    end

    assert_rdload_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |-> (st >= ST_WORD0 && st <= ST_TYPE));
endmodule

// File: rtl/supply_cmd_decoder.sv
module supply_cmd_decoder
    import supply_cmd_pkg::*;
#(
    parameter int unsigned DW            = 8,
    parameter int unsigned WAIT_TICKS    = 3277,
    parameter int unsigned TIMEOUT_TICKS = 65536,
    parameter int unsigned INC_LO        = 20,
    parameter int unsigned INC_HI        = 26,
    parameter int unsigned ZERO_LO       = 53,
    parameter int unsigned ZERO_HI       = 58,
    parameter int unsigned ONE_LO        = 86,
    parameter int unsigned ONE_HI        = 91,
    parameter logic [7:0]  TYPE_ID       = 8'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          ev_mod,
    input  logic          ev_prestore,
    input  logic          ev_store,
    output logic [2:0]    instr_state,
    output logic [DW-1:0] shreg,
    output logic          prog_wr,
    output logic          rd_load,
    output logic [DW-1:0] word0,
    output logic [DW-1:0] word1,
    output logic [DW-1:0] word2
);
    localparam int unsigned NWORDS = 3;
    localparam int unsigned CW     = $clog2(TIMEOUT_TICKS + 1);

    typedef struct packed {
        logic [2:0]    st;
        logic [DW-1:0] sh;
        logic [CW-1:0] cnt;
        logic          waited;
        logic          has_ref;
        logic          armed;
        logic          wr;
        logic [1:0]    wsel;
        logic [DW-1:0] wdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    ivl_e cls;
    logic active;
    logic [NWORDS*DW-1:0] words;

    interval_classifier #(
        .CW(CW), .INC_LO(INC_LO), .INC_HI(INC_HI),
        .ZERO_LO(ZERO_LO), .ZERO_HI(ZERO_HI),
        .ONE_LO(ONE_LO), .ONE_HI(ONE_HI)
    ) i_cls (
        .ticks (ctl_q.cnt),
        .cls   (cls)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.wr = 1'b0;
        active   = (ctl_q.st != ST_IDLE);
        if (ev_start) begin
            ctl_d.st      = ST_OSC;
            ctl_d.sh      = '0;
            ctl_d.cnt     = '0;
            ctl_d.waited  = 1'b0;
            ctl_d.has_ref = 1'b0;
            ctl_d.armed   = 1'b0;
        end else if (active) begin
            if (tick && ctl_q.cnt < CW'(TIMEOUT_TICKS)) begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            if (ctl_q.cnt >= CW'(WAIT_TICKS)) begin
                ctl_d.waited = 1'b1;
            end
            if (ev_stop || ctl_q.cnt >= CW'(TIMEOUT_TICKS)) begin
                ctl_d.st = ST_IDLE;
            end else if (ev_store) begin
                ctl_d.st = ST_IDLE;
                if (ctl_q.armed && ctl_q.st >= ST_WORD0 && ctl_q.st <= ST_WORD2) begin
                    ctl_d.wr    = 1'b1;
                    ctl_d.wsel  = 2'(ctl_q.st - ST_WORD0);
                    ctl_d.wdata = ctl_q.sh;
                end
            end else begin
                if (ev_prestore) begin
                    ctl_d.armed = 1'b1;
                end
                if (ev_mod && ctl_q.waited) begin
                    ctl_d.cnt     = '0;
                    ctl_d.has_ref = 1'b1;
                    if (ctl_q.has_ref) begin
                        unique case (cls)
                            IV_INC:  if (ctl_q.st < ST_TYPE) ctl_d.st = ctl_q.st + 1'b1;
                            IV_ZERO: ctl_d.sh = {1'b0, ctl_q.sh[DW-1:1]};
                            IV_ONE:  ctl_d.sh = {1'b1, ctl_q.sh[DW-1:1]};
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    otp_bank #(
        .DW(DW), .NWORDS(NWORDS), .TYPE_ID(TYPE_ID)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctl_q.wr),
        .wsel    (ctl_q.wsel),
        .wdata   (ctl_q.wdata),
        .st      (ctl_q.st),
        .ptr     (ctl_q.sh),
        .words   (words),
        .rd_load (rd_load)
    );

    assign instr_state = ctl_q.st;
    assign shreg       = ctl_q.sh;
    assign prog_wr     = ctl_q.wr;
    assign word0       = words[0*DW +: DW];
    assign word1       = words[1*DW +: DW];
    assign word2       = words[2*DW +: DW];

    assert_start_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (instr_state == ST_OSC && shreg == '0));

    assert_wait_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !ctl_q.waited && ev_mod && !ev_start && !ev_stop && !ev_store
         && ctl_q.cnt < CW'(TIMEOUT_TICKS)) |=> ($stable(instr_state) && $stable(shreg)));

    assert_state_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        instr_state <= ST_TYPE);

    assert_write_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_wr |-> ($past(instr_state) >= ST_WORD0 && $past(instr_state) <= ST_WORD2
                     && instr_state == ST_IDLE));

    assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_stop || ev_store) && !ev_start) |=> (instr_state == ST_IDLE));

    assert_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ctl_q.cnt >= CW'(TIMEOUT_TICKS) && !ev_start) |=> (instr_state == ST_IDLE));
endmodule

// File: tb/test_supply_cmd_decoder.sv
module test_supply_cmd_decoder;
    localparam int WAITT = 100;
    localparam int TMO   = 1000;
    localparam logic [7:0] TID = 8'h03;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
    logic ev_start = 0, ev_stop = 0, ev_mod = 0, ev_prestore = 0, ev_store = 0;
    logic [2:0] instr_state;
    logic [7:0] shreg, word0, word1, word2;
    logic prog_wr, rd_load;

    int checks = 0, errors = 0;
    int exp_st = 0;
    logic [7:0] exp_sh = 0;
    logic [7:0] exp_w [3];
    bit has_ref = 0, armed = 0, done = 0;

    always #2.5 clk = ~clk;

    supply_cmd_decoder #(.WAIT_TICKS(WAITT), .TIMEOUT_TICKS(TMO), .TYPE_ID(TID)) i_supply_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_mod(ev_mod), .ev_prestore(ev_prestore), .ev_store(ev_store),
        .instr_state(instr_state), .shreg(shreg), .prog_wr(prog_wr), .rd_load(rd_load),
        .word0(word0), .word1(word1), .word2(word2));

    function automatic int classify(int n);
        if (n >= 20 && n <= 26) return 1;
        if (n >= 53 && n <= 58) return 2;
        if (n >= 86 && n <= 91) return 3;
        return 0;
    endfunction

    function automatic logic exp_load(int st, logic [7:0] sh);
        logic [7:0] w;
        w = 8'h00;
        if (st >= 3 && st <= 5) w = exp_w[st-3];
        else if (st == 6) w = TID;
        return |(w & sh);
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic chk_core(string req);
        chk(instr_state == 3'(exp_st), req, instr_state, exp_st);
        chk(shreg == exp_sh, req, shreg, exp_sh);
        chk(rd_load == exp_load(exp_st, exp_sh), {req, "_R11"}, rd_load, exp_load(exp_st, exp_sh));
    endtask

    task automatic pulse_start();
        ev_start = 1; @(negedge clk); ev_start = 0;
        exp_st = 1; exp_sh = 0; has_ref = 0; armed = 0;
    endtask

    task automatic start_and_wait();
        pulse_start();
        repeat (WAITT + 10) @(negedge clk);
    endtask

    // n idle cycles, then one modulation pulse; model updated
    task automatic mod_after(int n);
        repeat (n) @(negedge clk);
        ev_mod = 1; @(negedge clk); ev_mod = 0;
        if (exp_st != 0) begin
            if (has_ref) begin
                case (classify(n))
                    1: if (exp_st < 6) exp_st++;
                    2: exp_sh = {1'b0, exp_sh[7:1]};
                    3: exp_sh = {1'b1, exp_sh[7:1]};
                    default: ;
                endcase
            end
            has_ref = 1;
        end
    endtask

    task automatic gap_for(int kind, output int n);
        case (kind)
            1: n = 20 + int'($urandom % 7);
            2: n = 53 + int'($urandom % 6);
            3: n = 86 + int'($urandom % 6);
            default: n = 30 + int'($urandom % 20);
        endcase
    endtask

    task automatic do_store(bit with_pre);
        if (with_pre) begin
            ev_prestore = 1; @(negedge clk); ev_prestore = 0;
            if (exp_st != 0) armed = 1;
        end
        ev_store = 1; @(negedge clk); ev_store = 0;
        if (exp_st != 0) begin
            if (armed && exp_st >= 3 && exp_st <= 5) exp_w[exp_st-3] |= exp_sh;
            exp_st = 0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_words(string req);
        chk(word0 == exp_w[0], req, word0, exp_w[0]);
        chk(word1 == exp_w[1], req, word1, exp_w[1]);
        chk(word2 == exp_w[2], req, word2, exp_w[2]);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int wr_seen;
        void'($urandom(32'd1234));
        foreach (exp_w[i]) exp_w[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R12 reset state
        chk(instr_state == 0 && shreg == 0 && !prog_wr && !rd_load, "R12", instr_state, 0);
        chk_words("R12");
        rst_n = 1;
        @(negedge clk);

        // R9 idle ignores modulation
        mod_after(5); mod_after(22);
        chk_core("R9_idle");

        // R1 start, R2 pulses inside the wait are ignored
        pulse_start();
        chk_core("R1");
        mod_after(5); mod_after(22); mod_after(22);
        // model: pulses ignored during wait
        exp_st = 1; has_ref = 0;
        chk_core("R2");
        repeat (WAITT) @(negedge clk);
        // R3 first accepted pulse only sets reference
        mod_after(3);
        chk_core("R3");
        // R4 window edges
        mod_after(19); chk_core("R6_low_edge");
        mod_after(20); chk_core("R4_low_edge");
        mod_after(26); chk_core("R4_high_edge");
        mod_after(27); chk_core("R6_high_edge");
        mod_after(53); chk_core("R5_zero_low");
        mod_after(91); chk_core("R5_one_high");
        mod_after(92); chk_core("R6_above_one");
        for (int i = 0; i < 5; i++) mod_after(23);
        chk_core("R4_saturate");
        // R10 timeout
        repeat (TMO - 20) @(negedge clk);
        chk(instr_state == 6, "R10_before", instr_state, 6);
        repeat (40) @(negedge clk);
        exp_st = 0;
        chk(instr_state == 0, "R10_after", instr_state, 0);

        // R8 store in type state writes nothing; stop ends state
        start_and_wait(); mod_after(1);
        for (int i = 0; i < 5; i++) mod_after(22);
        mod_after(88);
        do_store(1);
        chk_words("R8_type_nowrite");
        chk(instr_state == 0, "R9_store_idle", instr_state, 0);
        start_and_wait(); mod_after(1);
        mod_after(22); mod_after(22);
        mod_after(88);
        do_store(0);
        chk_words("R8_no_prestore");
        start_and_wait();
        ev_stop = 1; @(negedge clk); ev_stop = 0; exp_st = 0;
        chk(instr_state == 0, "R9_stop", instr_state, 0);

        // random programming of configuration words
        for (int it = 0; it < 18; it++) begin
            int tgt;
            tgt = 3 + int'($urandom % 3);
            start_and_wait(); mod_after(2);
            for (int s = 1; s < tgt; s++) begin gap_for(1, n); mod_after(n); end
            for (int b = 0; b < 8; b++) begin
                if ($urandom % 4 == 0) begin gap_for(0, n); mod_after(n); end
                gap_for(($urandom % 2) ? 3 : 2, n); mod_after(n);
            end
            chk_core("R5_random");
            ev_prestore = 1; @(negedge clk); ev_prestore = 0; armed = 1;
            ev_store = 1;
            @(negedge clk); ev_store = 0;
            wr_seen = prog_wr;
            chk(wr_seen == 1, "R8_strobe", wr_seen, 1);
            exp_w[tgt-3] |= exp_sh; exp_st = 0;
            @(negedge clk);
            chk(prog_wr == 0, "R8_single", prog_wr, 0);
            repeat (2) @(negedge clk);
            chk_words("R7_R8_random");
        end

        // R11 read-back walk for word 1 and for the type word
        for (int wsel = 4; wsel <= 6; wsel += 2) begin
            start_and_wait(); mod_after(1);
            for (int s = 1; s < wsel; s++) mod_after(24);
            mod_after(88);
            chk_core("R11_walk");
            for (int b = 0; b < 7; b++) begin
                mod_after(55);
                chk_core("R11_walk");
            end
            ev_stop = 1; @(negedge clk); ev_stop = 0; exp_st = 0;
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule